// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

This block turns 32 general-purpose input pins into four interrupt requests. Each pin is brought into the clock domain by a two-flop synchroniser. A per-pin inversion bit is then applied, giving an adjusted value that software can read. Two separately masked sources come from that one adjusted value. The level source is the adjusted value itself. The edge source is a sticky cause bit that records a low-to-high transition of the adjusted value. The inversion bit therefore picks active-high or active-low for levels, and rising or falling for edges.

The pins are split into four groups of eight. Each group drives one interrupt line, which is high while any pin in the group has an active masked cause. A per-pin direction bit must mark the pin as an input before that pin can record an edge or raise an interrupt.

Software uses a simple register port: a write strobe, a 3-bit word address, 32-bit write data and combinational read data.

Top module: `gpio_irq_cause`

## Requirements
- R1: After reset, the direction register (address 0) reads all ones, meaning every pin is an input. The inversion register (1), level mask (3), edge cause (4) and edge mask (5) read zero, and `irq_o` is zero.
- R2: Address 2 reads the synchronised pin value XOR the inversion register. A pin change driven before clock edge k appears in the read value after edge k+1, and not after edge k.
- R3: A write to the inversion register (address 1) changes the address-2 read value from the cycle after the write.
- R4: A pin whose adjusted value is 1 and whose level mask bit (address 3) is 1 raises the interrupt of its group. Setting the pin's inversion bit removes that request.
- R5: An edge cause bit (address 4) is set by a 0-to-1 transition of the adjusted value: a rising pin edge with inversion 0, or a falling pin edge with inversion 1. The bit stays set after the pin returns to its earlier level.
- R6: Changing an inversion bit never sets an edge cause bit.
- R7: Writing address 4 clears each cause bit written as 0 and leaves each bit written as 1 unchanged.
- R8: When an edge is detected in the same cycle as a clear of that bit, the bit ends up set.
- R9: An edge cause bit raises its group interrupt only while its edge mask bit (address 5) is 1.
- R10: `irq_o[g]` is the OR of the masked causes of pins 8g to 8g+7.
- R11: A pin whose direction bit is 0 records no edge cause and raises no interrupt, whatever its masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq_o | output | 4 | One interrupt request per group of 8 pins |

## Verification
The hardest case to reach from the ports is an edge that collides with a software clear of the same bit. To get there, the pin change must be placed so that the edge detector fires in exactly the cycle in which the write to address 4 is sampled. The bench counts the two synchroniser stages and the previous-value register. It raises the pin on a falling clock edge and asserts the clear-write two falling edges later. A second hard case is a polarity flip with a steady pin. The bench first clears every cause bit, then rewrites the inversion register, and checks that address 4 stays zero.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int GIC_AW = 3;

  typedef enum logic [GIC_AW-1:0] {
    REG_DIR    = 3'd0,
    REG_INV    = 3'd1,
    REG_DIN    = 3'd2,
    REG_LVLMSK = 3'd3,
    REG_ECAUSE = 3'd4,
    REG_EDGMSK = 3'd5
  } gic_reg_e;
endpackage

// File: rtl/gic_rst_sync.sv
module gic_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/gic_sync.sv
module gic_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (s == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= src;
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gic_edge_cause.sv
module gic_edge_cause #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] inv_i,
  input  logic [WIDTH-1:0] in_mask_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] cause_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] cause_q, cause_d;
  logic [WIDTH-1:0] adj_now, adj_prev, edge_set, keep;

  // Both samples are adjusted with the current inversion bits, so a flip of
  // the inversion register alone produces no transition.
  assign adj_now  = sync_i ^ inv_i;
  assign adj_prev = prev_q ^ inv_i;
  assign edge_set = adj_now & ~adj_prev & in_mask_i;
  assign keep     = clr_we_i ? clr_data_i : {WIDTH{1'b1}};

  always_comb begin
    cause_d = (cause_q & keep) | edge_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      cause_q <= '0;
    end else begin
      prev_q  <= sync_i;
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;

  AST_EDGE_NEEDS_PIN_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~($past(sync_i) ^ $past(prev_q))) == '0)); // R6
  AST_EDGE_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(in_mask_i)) == '0)); // R11
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((cause_q & ~$past(clr_data_i) & ~$past(edge_set)) == '0)); // R7
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((cause_q & $past(edge_set)) == $past(edge_set))); // R8
endmodule

// File: rtl/gic_group_or.sv
module gic_group_or #(
  parameter int WIDTH = 32,
  parameter int GRP_W = 8,
  localparam int NGRP = WIDTH / GRP_W
) (
  input  logic [WIDTH-1:0] cause_i,
  output logic [NGRP-1:0]  irq_o
);
  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign irq_o[g] = |cause_i[g*GRP_W +: GRP_W];
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause
  import gic_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int GRP_W  = 8,
  localparam int NGRP  = N_PINS / GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              reg_we,
  input  logic [GIC_AW-1:0] reg_addr,
  input  logic [N_PINS-1:0] reg_wdata,
  output logic [N_PINS-1:0] reg_rdata,
  output logic [NGRP-1:0]   irq_o
);
  logic rst_int_n;
  logic [N_PINS-1:0] sync_v, din_v, ecause_v, total_cause;
  logic [N_PINS-1:0] dir_q, dir_d, inv_q, inv_d, lvl_q, lvl_d, emsk_q, emsk_d;
  logic we_dir, we_inv, we_lvl, we_emsk, we_cause;
  gic_reg_e addr_e;

  gic_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_int_n));

  gic_sync #(.WIDTH(N_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(pin_i), .q_o(sync_v));

  assign addr_e   = gic_reg_e'(reg_addr);
  assign we_dir   = reg_we && (addr_e == REG_DIR);
  assign we_inv   = reg_we && (addr_e == REG_INV);
  assign we_lvl   = reg_we && (addr_e == REG_LVLMSK);
  assign we_emsk  = reg_we && (addr_e == REG_EDGMSK);
  assign we_cause = reg_we && (addr_e == REG_ECAUSE);

  always_comb begin
    dir_d  = we_dir  ? reg_wdata : dir_q;
    inv_d  = we_inv  ? reg_wdata : inv_q;
    lvl_d  = we_lvl  ? reg_wdata : lvl_q;
    emsk_d = we_emsk ? reg_wdata : emsk_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q  <= '1;
      inv_q  <= '0;
      lvl_q  <= '0;
      emsk_q <= '0;
    end else begin
      dir_q  <= dir_d;
      inv_q  <= inv_d;
      lvl_q  <= lvl_d;
      emsk_q <= emsk_d;
    end
  end

  assign din_v = sync_v ^ inv_q;

  gic_edge_cause #(.WIDTH(N_PINS)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .sync_i(sync_v), .inv_i(inv_q),
    .in_mask_i(dir_q), .clr_we_i(we_cause), .clr_data_i(reg_wdata),
    .cause_o(ecause_v));

  assign total_cause = ((din_v & lvl_q) | (ecause_v & emsk_q)) & dir_q;

  gic_group_or #(.WIDTH(N_PINS), .GRP_W(GRP_W)) u_grp (
    .cause_i(total_cause), .irq_o(irq_o));

  always_comb begin
    unique case (addr_e)
      REG_DIR:    reg_rdata = dir_q;
      REG_INV:    reg_rdata = inv_q;
      REG_DIN:    reg_rdata = din_v;
      REG_LVLMSK: reg_rdata = lvl_q;
      REG_ECAUSE: reg_rdata = ecause_v;
      REG_EDGMSK: reg_rdata = emsk_q;
      default:    reg_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_o != '0) |-> (dir_q != '0)); // R11
  AST_LEVEL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((din_v & lvl_q & dir_q) != '0) |-> (irq_o != '0)); // R4
  AST_EDGE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((ecause_v & emsk_q & dir_q) != '0) |-> (irq_o != '0)); // R9
endmodule

// File: tb/tb_gpio_irq_cause.sv
module tb_gpio_irq_cause;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_i;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  gpio_irq_cause dut (.clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  // Monitor: pop expected items and compare against the outputs.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.is_irq ? {28'd0, irq_o} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic exp_reg(input logic [2:0] a, input logic [31:0] e, input string r);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.is_irq = 0; it.exp = e; it.req = r;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic exp_irq(input logic [3:0] e, input string r);
    item_t it;
    @(negedge clk);
    it.is_irq = 1; it.exp = {28'd0, e}; it.req = r;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic setpins(input logic [31:0] v);
    @(negedge clk);
    pin_i = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pin_i = '0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    exp_reg(3'd0, 32'hFFFF_FFFF, "R1 dir");
    exp_reg(3'd1, 32'h0, "R1 inv");
    exp_reg(3'd3, 32'h0, "R1 lvl");
    exp_reg(3'd4, 32'h0, "R1 cause");
    exp_reg(3'd5, 32'h0, "R1 emsk");
    exp_irq(4'h0, "R1 irq");

    // R2 data-in and synchroniser latency
    setpins(32'h0000_00A5);
    settle();
    exp_reg(3'd2, 32'h0000_00A5, "R2 data");
    setpins(32'h0000_01A5);
    exp_reg(3'd2, 32'h0000_00A5, "R2 not yet");
    exp_reg(3'd2, 32'h0000_01A5, "R2 two stages");

    // R3 / R6 inversion write
    wr(3'd4, 32'h0);
    exp_reg(3'd4, 32'h0, "R7 clear all");
    wr(3'd1, 32'hFFFF_FFFF);
    exp_reg(3'd2, 32'hFFFF_FE5A, "R3 inverted");
    exp_reg(3'd4, 32'h0, "R6 inv flip");
    wr(3'd1, 32'h0);
    exp_reg(3'd4, 32'h0, "R6 inv back");

    // R4 level
    wr(3'd3, 32'h0000_0001);
    exp_irq(4'h1, "R4 level high");
    wr(3'd1, 32'h0000_0001);
    exp_irq(4'h0, "R4 level inverted");
    wr(3'd1, 32'h0);
    wr(3'd3, 32'h0);

    // R5 / R7 / R10 rising edge
    setpins(32'h0);
    settle();
    wr(3'd4, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    setpins(32'h0000_0200);
    settle();
    exp_reg(3'd4, 32'h0000_0200, "R5 rising");
    exp_irq(4'h2, "R10 group1");
    setpins(32'h0);
    settle();
    exp_reg(3'd4, 32'h0000_0200, "R5 sticky");
    wr(3'd4, 32'hFFFF_FFFF);
    exp_reg(3'd4, 32'h0000_0200, "R7 write one keeps");
    wr(3'd4, ~32'h0000_0200);
    exp_reg(3'd4, 32'h0, "R7 write zero clears");
    exp_irq(4'h0, "R7 irq drops");

    // R5 falling edge via inversion
    wr(3'd1, 32'h0002_0000);
    exp_reg(3'd4, 32'h0, "R6 inv set");
    setpins(32'h0002_0000);
    settle();
    exp_reg(3'd4, 32'h0, "R5 rise ignored when inverted");
    setpins(32'h0);
    settle();
    exp_reg(3'd4, 32'h0002_0000, "R5 falling");
    exp_irq(4'h4, "R10 group2");
    wr(3'd1, 32'h0);
    wr(3'd4, 32'h0);

    // R9 edge mask
    wr(3'd5, 32'h0);
    setpins(32'h0200_0000);
    settle();
    exp_reg(3'd4, 32'h0200_0000, "R9 latched");
    exp_irq(4'h0, "R9 masked");
    wr(3'd5, 32'hFFFF_FFFF);
    exp_irq(4'h8, "R9 unmasked");
    setpins(32'h0);
    settle();
    wr(3'd4, 32'h0);

    // R8 edge beats clear in the same cycle
    setpins(32'h0000_0008);
    @(negedge clk);
    @(negedge clk);
    reg_we = 1; reg_addr = 3'd4; reg_wdata = 32'h0;
    @(negedge clk);
    reg_we = 0;
    exp_reg(3'd4, 32'h0000_0008, "R8 edge wins");
    setpins(32'h0);
    settle();
    wr(3'd4, 32'h0);

    // R11 output pin
    wr(3'd0, ~32'h4000_0000);
    setpins(32'h4000_0000);
    settle();
    exp_reg(3'd4, 32'h0, "R11 no edge");
    wr(3'd3, 32'h4000_0000);
    exp_irq(4'h0, "R11 no level irq");
    wr(3'd0, 32'hFFFF_FFFF);
    exp_irq(4'h8, "R11 input again");
    wr(3'd3, 32'h0);
    wr(3'd5, 32'h0);

    // R10 all groups
    wr(3'd3, 32'hFFFF_FFFF);
    setpins(32'h0101_0101);
    settle();
    exp_irq(4'hF, "R10 all groups");
    setpins(32'h0100_0001);
    settle();
    exp_irq(4'h9, "R10 groups 0 and 3");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule